// File: doc/BRIEF.md
# Eight-bit Timer/Counter with Clear-on-Compare

This block is an up-counter that moves forward only on cycles where a timer-clock enable strobe is high. A two-bit mode field selects one of two behaviours. In free-running mode the count rolls over from 0xFF to 0x00. In clear-on-compare mode the count returns to zero on the strobe that follows a match against a compare register.

Two sticky flags record events. One flag marks a wrap to zero and the other marks a compare match. A waveform pin can be set to toggle on every match. Software reaches the counter, the compare register, the control fields and the flags through single-cycle write strobes that share one data bus. Each flag can also be cleared by a one-cycle acknowledge pulse.

The compare register is not double buffered. A new compare value takes effect at once. If that value is below the running count, the counter has to pass through 0xFF and 0x00 before the next match can occur.

Top module: `tc8_ctc`

## Requirements
- R1: After reset the count, the compare value, the mode and output-mode fields, both flags and the waveform pin are all zero.
- R2: The count changes only on a cycle where `tick` or `wr_cnt` is high. On any other cycle it holds its value.
- R3: With mode 0 (free-running), each strobe adds one to the count and 0xFF is followed by 0x00. A compare match never clears the count.
- R4: The overflow flag goes high in the same cycle in which the count steps from 0xFF to 0x00 on a strobe. Counting never clears it.
- R5: With mode 2 (clear-on-compare), a strobe taken while the count equals the compare value loads zero into the count instead of the incremented value.
- R6: In either mode, the compare flag goes high on every strobe taken while the count equals the compare value.
- R7: A compare write takes effect on the next cycle with no buffering. If the new value is below the count, no match occurs until the count has wrapped through 0x00 and climbed to the new value.
- R8: When the output-mode field equals 1, the waveform pin inverts on every match strobe. Any other output-mode value leaves the pin unchanged.
- R9: A counter write loads `wdata` and overrides a strobe in the same cycle. That cycle signals no compare match, no overflow and no pin toggle.
- R10: A flag write with `wdata[0]`=1 clears the overflow flag, and one with `wdata[1]`=1 clears the compare flag. `ack_ovf` and `ack_cmp` clear their flag in the same way. If a set and a clear fall in the same cycle, the set wins.
- R11: A control write takes the mode from `wdata[1:0]` and the output-mode from `wdata[5:4]`. Both fields read back on `mode` and `com`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer-clock enable strobe |
| wr_cnt | input | 1 | Write `wdata` into the count |
| wr_cmp | input | 1 | Write `wdata` into the compare register |
| wr_ctl | input | 1 | Write the mode and output-mode fields |
| wr_flg | input | 1 | Write-one-to-clear for the flags |
| wdata | input | 8 | Shared write data |
| ack_ovf | input | 1 | Acknowledge pulse that clears the overflow flag |
| ack_cmp | input | 1 | Acknowledge pulse that clears the compare flag |
| count | output | 8 | Current count |
| cmp_val | output | 8 | Compare register |
| mode | output | 2 | Mode field (0 free-running, 2 clear-on-compare) |
| com | output | 2 | Output-mode field (1 toggle) |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare-match flag |
| wave_out | output | 1 | Waveform pin |

## Verification
Every result in this block has a latency of exactly one clock. A strobe or a write sampled at a rising edge shows up on the count, the flags and the pin just after that same edge, and nothing ever takes two edges. The bench changes inputs on the falling edge, lets exactly one rising edge pass for each strobe it means to apply, and reads outputs on the next falling edge. A run of N strobes therefore gives a count that can be predicted with simple arithmetic. The missed-match and wrap cases are checked by counting out the exact number of strobes up to 0xFF and then stepping one strobe at a time across the boundary.

// File: rtl/tc8_ctc.sv
module tc8_ctc #(
  parameter int         W        = 8,
  parameter logic [1:0] MODE_CTC = 2'd2,
  parameter logic [1:0] COM_TGL  = 2'd1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_cnt,
  input  logic         wr_cmp,
  input  logic         wr_ctl,
  input  logic         wr_flg,
  input  logic [W-1:0] wdata,
  input  logic         ack_ovf,
  input  logic         ack_cmp,
  output logic [W-1:0] count,
  output logic [W-1:0] cmp_val,
  output logic [1:0]   mode,
  output logic [1:0]   com,
  output logic         ovf_flag,
  output logic         cmp_flag,
  output logic         wave_out
);

  logic step, hit, at_top, ctc;

  assign step   = tick & ~wr_cnt;
  assign hit    = (count == cmp_val);
  assign at_top = (count == {W{1'b1}});
  assign ctc    = (mode == MODE_CTC);

  always_ff @(posedge clk) begin
    if (!rst_n)            count <= '0;
    else if (wr_cnt)       count <= wdata;
    else if (tick)         count <= (ctc && hit) ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cmp_val <= '0;
    else if (wr_cmp) cmp_val <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
      com  <= '0;
    end else if (wr_ctl) begin
      mode <= wdata[1:0];
      com  <= wdata[5:4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             ovf_flag <= 1'b0;
    else if (step && at_top)                ovf_flag <= 1'b1;
    else if ((wr_flg && wdata[0]) || ack_ovf) ovf_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             cmp_flag <= 1'b0;
    else if (step && hit)                   cmp_flag <= 1'b1;
    else if ((wr_flg && wdata[1]) || ack_cmp) cmp_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                wave_out <= 1'b0;
    else if (step && hit && com == COM_TGL)    wave_out <= ~wave_out;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(count));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (count == $past(wdata)));

  assert_ctc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ctc && hit) |=> (count == '0));

  assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_top) |=> (ovf_flag && count == '0));

  assert_match_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hit) |=> cmp_flag);

  assert_pin_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && hit && com == COM_TGL) |=> $stable(wave_out));

endmodule

// File: tb/tc8_ctc_tb.sv
module tc8_ctc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_cnt = 1'b0, wr_cmp = 1'b0, wr_ctl = 1'b0, wr_flg = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       ack_ovf = 1'b0, ack_cmp = 1'b0;
  logic [7:0] count, cmp_val;
  logic [1:0] mode, com;
  logic       ovf_flag, cmp_flag, wave_out;

  int vec = 0;
  int bad = 0;

  tc8_ctc u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_cnt(wr_cnt), .wr_cmp(wr_cmp),
    .wr_ctl(wr_ctl), .wr_flg(wr_flg), .wdata(wdata), .ack_ovf(ack_ovf),
    .ack_cmp(ack_cmp), .count(count), .cmp_val(cmp_val), .mode(mode), .com(com),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .wave_out(wave_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic run(input int n);
    tick = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    tick = 1'b0;
  endtask

  // sel: 0 count, 1 compare, 2 control, 3 flags
  task automatic wr(input int sel, input logic [7:0] v, input logic tk);
    wdata = v; tick = tk;
    wr_cnt = (sel == 0); wr_cmp = (sel == 1); wr_ctl = (sel == 2); wr_flg = (sel == 3);
    @(negedge clk);
    wr_cnt = 0; wr_cmp = 0; wr_ctl = 0; wr_flg = 0; tick = 0;
  endtask

  task automatic ack(input logic o, input logic c, input logic tk);
    ack_ovf = o; ack_cmp = c; tick = tk;
    @(negedge clk);
    ack_ovf = 0; ack_cmp = 0; tick = 0;
  endtask

  task automatic t_reset;
    chk("R1 count", count, 0);     chk("R1 cmp", cmp_val, 0);
    chk("R1 mode", mode, 0);       chk("R1 com", com, 0);
    chk("R1 ovf", ovf_flag, 0);    chk("R1 cmpf", cmp_flag, 0);
    chk("R1 wave", wave_out, 0);
  endtask

  task automatic t_hold;
    wr(0, 8'h05, 1'b0);
    chk("R9 load", count, 5);
    repeat (3) @(negedge clk);
    chk("R2 hold", count, 5);
    run(2);
    chk("R2 advance", count, 7);
  endtask

  task automatic t_normal;
    wr(2, 8'h00, 1'b0);
    wr(3, 8'h03, 1'b0);
    wr(1, 8'h10, 1'b0);
    wr(0, 8'h0E, 1'b0);
    run(4);
    chk("R3 no clear on match", count, 8'h12);
    chk("R6 match flag normal", cmp_flag, 1);
    wr(0, 8'hFD, 1'b0);
    run(2);
    chk("R3 at top", count, 8'hFF);
    chk("R4 ovf not yet", ovf_flag, 0);
    run(1);
    chk("R3 wrap", count, 0);
    chk("R4 ovf set", ovf_flag, 1);
    run(5);
    chk("R4 ovf sticky", ovf_flag, 1);
  endtask

  task automatic t_flags;
    wr(3, 8'h01, 1'b0);
    chk("R10 w1c ovf", ovf_flag, 0);
    chk("R10 cmp untouched", cmp_flag, 1);
    ack(1'b0, 1'b1, 1'b0);
    chk("R10 ack cmp", cmp_flag, 0);
    wr(0, 8'hFF, 1'b0);
    ack(1'b1, 1'b0, 1'b1);
    chk("R10 set beats ack", ovf_flag, 1);
    ack(1'b1, 1'b0, 1'b0);
    chk("R10 ack ovf", ovf_flag, 0);
  endtask

  task automatic t_ctc;
    wr(2, 8'h12, 1'b0);
    chk("R11 mode", mode, 2);
    chk("R11 com", com, 1);
    wr(3, 8'h03, 1'b0);
    wr(1, 8'h03, 1'b0);
    wr(0, 8'h00, 1'b0);
    run(3);
    chk("R5 reach top", count, 3);
    chk("R8 wave before", wave_out, 0);
    run(1);
    chk("R5 cleared", count, 0);
    chk("R6 ctc flag", cmp_flag, 1);
    chk("R8 toggle 1", wave_out, 1);
    run(4);
    chk("R5 period", count, 0);
    chk("R8 toggle 2", wave_out, 0);
  endtask

  task automatic t_miss;
    wr(0, 8'h50, 1'b0);
    wr(1, 8'h20, 1'b0);
    wr(3, 8'h03, 1'b0);
    run(8'hAF);
    chk("R7 ran to top", count, 8'hFF);
    chk("R7 no early match", cmp_flag, 0);
    run(1);
    chk("R7 wrap", count, 0);
    chk("R4 ovf in ctc", ovf_flag, 1);
    run(8'h20);
    chk("R7 climb", count, 8'h20);
    chk("R7 still no match", cmp_flag, 0);
    run(1);
    chk("R7 match after wrap", count, 0);
    chk("R7 flag after wrap", cmp_flag, 1);
  endtask

  task automatic t_prio;
    logic w0;
    wr(1, 8'h07, 1'b0);
    wr(0, 8'h07, 1'b0);
    wr(3, 8'h03, 1'b0);
    w0 = wave_out;
    wr(0, 8'h30, 1'b1);
    chk("R9 write over tick", count, 8'h30);
    chk("R9 no match flag", cmp_flag, 0);
    chk("R9 no toggle", wave_out, w0);
    wr(0, 8'hFF, 1'b0);
    wr(0, 8'h40, 1'b1);
    chk("R9 no ovf", ovf_flag, 0);
  endtask

  task automatic t_com_off;
    logic w0;
    wr(2, 8'h02, 1'b0);
    chk("R11 mode ctc", mode, 2);
    chk("R11 com off", com, 0);
    wr(1, 8'h02, 1'b0);
    wr(0, 8'h02, 1'b0);
    wr(3, 8'h03, 1'b0);
    w0 = wave_out;
    run(1);
    chk("R5 clear com off", count, 0);
    chk("R6 flag com off", cmp_flag, 1);
    chk("R8 no toggle com 0", wave_out, w0);
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_hold;
    t_normal;
    t_flags;
    t_ctc;
    t_miss;
    t_prio;
    t_com_off;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule